// File: doc/BRIEF.md
# Programmable AND / Fixed OR Logic Array

This block is the combinational heart of a small sum-of-products logic device. Ten dedicated input signals and eight feedback signals are each split into a true line and a complement line, which gives 36 array lines. A flat configuration vector decides which lines take part in each of 74 wide AND gates, called product terms. Sixty-four of these terms are hard-wired in groups of eight into eight OR gates, which produce the sum outputs. The remaining ten terms are passed out unchanged. Eight of them are per-output enable terms. One is a global preset term and one is a global clear term.

A cleared configuration bit means "not connected". A term with no connections is therefore constantly true. A term that is tied to both polarities of the same signal is constantly false and drops out of its OR gate. The surrounding device owns the configuration storage, the macrocells and the pin drivers. This block only evaluates the array, and it contains no storage of any kind.

Top module: `sop_logic_array`

## Requirements
- R1: Signal s drives array line 2s with its true value and line 2s+1 with its complement. Signals 0 to 9 are the dedicated inputs `dedIn[0]` to `dedIn[9]`. A term that is connected only to line 2s equals that input, and a term connected only to line 2s+1 equals its inverse.
- R2: A product term with no connection bits set evaluates to 1 for every input value.
- R3: A product term that is connected to both line 2s and line 2s+1 of any one signal evaluates to 0 for every input value. A group made only of such terms gives a sum output of 0.
- R4: `sumOut[g]` is the OR of product terms 8g through 8g+7. Term 8g+k reads configuration bits (8g+k)*36 through (8g+k)*36+35, and bit term*36+line set to 1 means that line is connected.
- R5: `oeTerm[g]` is the value of product term 64+g, for g from 0 to 7.
- R6: `syncPreset` is the value of product term 72, and `asyncClear` is the value of product term 73.
- R7: Feedback signal f is array signal 10+f. It drives line 20+2f true and line 21+2f complemented.
- R8: All outputs depend only on the present inputs and configuration. A change on any input is visible at the outputs without any clock edge.
- R9: A term that has several connections is 1 exactly when every connected line is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dedIn | input | 10 | Dedicated input signals; bit s is array signal s |
| fbIn | input | 8 | Feedback signals; bit f is array signal 10+f |
| connMap | input | 2664 | Connection bits; bit term*36+line is 1 when that line joins that term |
| sumOut | output | 8 | OR of each group of eight product terms |
| oeTerm | output | 8 | Per-output enable product terms |
| syncPreset | output | 1 | Global synchronous preset product term |
| asyncClear | output | 1 | Global asynchronous clear product term |

## Verification
The block holds no state. A wrong internal result is therefore a wrongly wired or wrongly evaluated line or term, and it shows at the ports in the same cycle as the stimulus that exposes it. Possible faults of this kind include a swapped polarity, a misplaced feedback line, a slipped group boundary, or inverted erased-bit handling. The directed cases place single connections on the directly visible enable, preset and clear terms, so that a wrong line order or polarity appears on one output bit. They also use constant-true and constant-false terms to isolate each OR group. A random phase with sparse configurations then compares every output against an independent model, which catches faults that stay hidden unless several terms interact.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;
  // Number of sum outputs; this also sizes the enable field of the control struct.
  localparam int OUT_COUNT = 8;

  // Control-side terms passed out beside the sums.
  typedef struct packed {
    logic [OUT_COUNT-1:0] oeTerm;
    logic                 syncPreset;
    logic                 asyncClear;
  } ctrl_terms_t;

  // Array line carrying the true value of signal sig.
  function automatic int trueLine(input int sig);
    return 2 * sig;
  endfunction

  // Array line carrying the complement of signal sig.
  function automatic int compLine(input int sig);
    return 2 * sig + 1;
  endfunction
endpackage

// File: rtl/line_expander.sv
module line_expander #(
  parameter int NUM_SIG = 18
) (
  input  logic [NUM_SIG-1:0]   sigIn,
  output logic [2*NUM_SIG-1:0] lineOut
);
  import sop_array_pkg::*;

  // Each signal drives its true line followed by its complement line.
  for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
    assign lineOut[trueLine(s)] = sigIn[s];
    assign lineOut[compLine(s)] = ~sigIn[s];
  end
endmodule

// File: rtl/term_plane.sv
module term_plane #(
  parameter int NUM_LINES = 36,
  parameter int NUM_TERMS = 74
) (
  input  logic [NUM_LINES-1:0]           lineIn,
  input  logic [NUM_TERMS*NUM_LINES-1:0] connMap,
  output logic [NUM_TERMS-1:0]           termOut
);
  // An open (0) bit forces its line to 1 inside the AND, so an all-open term is true.
  // Both polarities of one signal connected gives x & ~x, which is false.
  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    logic [NUM_LINES-1:0] masked;
    assign masked     = lineIn | ~connMap[t*NUM_LINES +: NUM_LINES];
    assign termOut[t] = &masked;
  end
endmodule

// File: rtl/or_plane.sv
module or_plane #(
  parameter int NUM_OUT       = 8,
  parameter int TERMS_PER_OUT = 8
) (
  input  logic [NUM_OUT*TERMS_PER_OUT-1:0] sopTerms,
  output logic [NUM_OUT-1:0]               sumOut
);
  // Fixed OR: output g takes the g-th group of consecutive terms.
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_grp
    assign sumOut[g] = |sopTerms[g*TERMS_PER_OUT +: TERMS_PER_OUT];
  end
endmodule

// File: rtl/ctrl_term_tap.sv
module ctrl_term_tap
  import sop_array_pkg::*;
#(
  parameter int NUM_OUT = OUT_COUNT
) (
  input  logic [NUM_OUT+1:0] ctrlRaw,
  output ctrl_terms_t        ctrlOut
);
  // Raw order: the enable terms first, then preset, then clear (the last term).
  assign ctrlOut.oeTerm     = ctrlRaw[NUM_OUT-1:0];
  assign ctrlOut.syncPreset = ctrlRaw[NUM_OUT];
  assign ctrlOut.asyncClear = ctrlRaw[NUM_OUT+1];
endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
  import sop_array_pkg::*;
#(
  parameter int NUM_PINS      = 10,
  parameter int NUM_FB        = 8,
  parameter int TERMS_PER_OUT = 8,
  localparam int NUM_OUT      = OUT_COUNT,
  localparam int NUM_SIG      = NUM_PINS + NUM_FB,
  localparam int NUM_LINES    = 2 * NUM_SIG,
  localparam int NUM_SOP      = NUM_OUT * TERMS_PER_OUT,
  localparam int NUM_TERMS    = NUM_SOP + NUM_OUT + 2,
  localparam int MAP_BITS     = NUM_TERMS * NUM_LINES
) (
  input  logic [NUM_PINS-1:0] dedIn,
  input  logic [NUM_FB-1:0]   fbIn,
  input  logic [MAP_BITS-1:0] connMap,
  output logic [NUM_OUT-1:0]  sumOut,
  output logic [NUM_OUT-1:0]  oeTerm,
  output logic                syncPreset,
  output logic                asyncClear
);
  logic [NUM_SIG-1:0]   sigAll;
  logic [NUM_LINES-1:0] arrayLines;
  logic [NUM_TERMS-1:0] allTerms;
  ctrl_terms_t          ctrlTerms;

  // Dedicated inputs occupy the low signal numbers, feedbacks follow.
  assign sigAll = {fbIn, dedIn};

  line_expander #(.NUM_SIG(NUM_SIG)) u_lines (
    .sigIn   (sigAll),
    .lineOut (arrayLines)
  );

  term_plane #(.NUM_LINES(NUM_LINES), .NUM_TERMS(NUM_TERMS)) u_terms (
    .lineIn  (arrayLines),
    .connMap (connMap),
    .termOut (allTerms)
  );

  or_plane #(.NUM_OUT(NUM_OUT), .TERMS_PER_OUT(TERMS_PER_OUT)) u_or (
    .sopTerms (allTerms[NUM_SOP-1:0]),
    .sumOut   (sumOut)
  );

  ctrl_term_tap #(.NUM_OUT(NUM_OUT)) u_ctrl (
    .ctrlRaw (allTerms[NUM_TERMS-1:NUM_SOP]),
    .ctrlOut (ctrlTerms)
  );

  assign oeTerm     = ctrlTerms.oeTerm;
  assign syncPreset = ctrlTerms.syncPreset;
  assign asyncClear = ctrlTerms.asyncClear;
endmodule

// File: rtl/sop_logic_array_checker.sv
module sop_logic_array_checker #(
  parameter int NUM_PINS      = 10,
  parameter int NUM_FB        = 8,
  parameter int TERMS_PER_OUT = 8,
  parameter int NUM_OUT       = 8,
  localparam int NUM_SIG      = NUM_PINS + NUM_FB,
  localparam int NUM_LINES    = 2 * NUM_SIG,
  localparam int NUM_SOP      = NUM_OUT * TERMS_PER_OUT,
  localparam int NUM_TERMS    = NUM_SOP + NUM_OUT + 2,
  localparam int MAP_BITS     = NUM_TERMS * NUM_LINES
) (
  input logic [MAP_BITS-1:0] connMap,
  input logic [NUM_OUT-1:0]  sumOut,
  input logic [NUM_OUT-1:0]  oeTerm,
  input logic                syncPreset,
  input logic                asyncClear
);
  // True when term t has no connection bits set.
  function automatic logic isOpen(input int t);
    return connMap[t*NUM_LINES +: NUM_LINES] == '0;
  endfunction

  // True when term t is tied to both polarities of some signal.
  function automatic logic isContra(input int t);
    logic hit;
    hit = 1'b0;
    for (int s = 0; s < NUM_SIG; s++) begin
      if (connMap[t*NUM_LINES + 2*s] && connMap[t*NUM_LINES + 2*s + 1]) hit = 1'b1;
    end
    return hit;
  endfunction

  always_comb begin
    for (int g = 0; g < NUM_OUT; g++) begin : c_oe
      if (isOpen(NUM_SOP + g))
        assert_oe_open_true_R5: assert (oeTerm[g])
          else $error("open enable term %0d is not true", g);
    end
  end

  always_comb begin
    if (isOpen(NUM_SOP + NUM_OUT))
      assert_preset_open_true_R2: assert (syncPreset)
        else $error("open preset term is not true");
    if (isContra(NUM_TERMS - 1))
      assert_clear_contra_false_R3: assert (!asyncClear)
        else $error("contradictory clear term is not false");
  end

  always_comb begin
    for (int g = 0; g < NUM_OUT; g++) begin : c_sum
      logic anyOpen;
      logic allContra;
      anyOpen   = 1'b0;
      allContra = 1'b1;
      for (int k = 0; k < TERMS_PER_OUT; k++) begin
        if (isOpen(g*TERMS_PER_OUT + k)) anyOpen = 1'b1;
        if (!isContra(g*TERMS_PER_OUT + k)) allContra = 1'b0;
      end
      if (anyOpen)
        assert_sum_open_true_R4: assert (sumOut[g])
          else $error("sum %0d low with an open term in its group", g);
      if (allContra)
        assert_sum_contra_false_R3: assert (!sumOut[g])
          else $error("sum %0d high with only contradictory terms", g);
    end
  end
endmodule

bind sop_logic_array sop_logic_array_checker #(
  .NUM_PINS      (NUM_PINS),
  .NUM_FB        (NUM_FB),
  .TERMS_PER_OUT (TERMS_PER_OUT),
  .NUM_OUT       (NUM_OUT)
) u_checker (
  .connMap    (connMap),
  .sumOut     (sumOut),
  .oeTerm     (oeTerm),
  .syncPreset (syncPreset),
  .asyncClear (asyncClear)
);

// File: tb/sop_logic_array_bench.sv
module sop_logic_array_bench;
  localparam int NP  = 10;
  localparam int NF  = 8;
  localparam int NO  = 8;
  localparam int TPO = 8;
  localparam int NS  = NP + NF;
  localparam int NL  = 2 * NS;
  localparam int NSOP = NO * TPO;
  localparam int NT  = NSOP + NO + 2;
  localparam int MB  = NT * NL;
  localparam int TERM_PRESET = NSOP + NO;
  localparam int TERM_CLEAR  = NSOP + NO + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;  // 250 MHz

  logic [NP-1:0] dedIn   = '0;
  logic [NF-1:0] fbIn    = '0;
  logic [MB-1:0] connMap = '0;
  logic [NO-1:0] sumOut;
  logic [NO-1:0] oeTerm;
  logic          syncPreset;
  logic          asyncClear;

  sop_logic_array u_sop_logic_array (
    .dedIn      (dedIn),
    .fbIn       (fbIn),
    .connMap    (connMap),
    .sumOut     (sumOut),
    .oeTerm     (oeTerm),
    .syncPreset (syncPreset),
    .asyncClear (asyncClear)
  );

  typedef struct {
    logic [NO-1:0] sum;
    logic [NO-1:0] oe;
    logic          pre;
    logic          clr;
    string         tag;
  } exp_t;

  exp_t expQ[$];
  int   nChecks = 0;
  int   nFails  = 0;
  bit   doneFlag = 1'b0;

  // Independent model built from the requirements.
  function automatic logic [NT-1:0] modelTerms(input logic [MB-1:0] c,
                                               input logic [NP-1:0] d,
                                               input logic [NF-1:0] f);
    logic [NL-1:0] ln;
    logic [NT-1:0] r;
    for (int s = 0; s < NS; s++) begin
      logic v;
      v = (s < NP) ? d[s] : f[s-NP];
      ln[2*s]   = v;
      ln[2*s+1] = !v;
    end
    for (int t = 0; t < NT; t++) begin
      r[t] = 1'b1;
      for (int l = 0; l < NL; l++) if (c[t*NL+l] && !ln[l]) r[t] = 1'b0;
    end
    return r;
  endfunction

  task automatic applyVec(input logic [MB-1:0] c, input logic [NP-1:0] d,
                          input logic [NF-1:0] f, input string tag);
    logic [NT-1:0] tm;
    exp_t e;
    @(posedge clk);
    connMap = c;
    dedIn   = d;
    fbIn    = f;
    tm = modelTerms(c, d, f);
    for (int g = 0; g < NO; g++) e.sum[g] = |tm[g*TPO +: TPO];
    e.oe  = tm[NSOP +: NO];
    e.pre = tm[TERM_PRESET];
    e.clr = tm[TERM_CLEAR];
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: samples half a cycle after each drive (R8: no clock involved).
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        nChecks++;
        if (sumOut !== e.sum || oeTerm !== e.oe || syncPreset !== e.pre || asyncClear !== e.clr) begin
          nFails++;
          $display("FAIL %s: got sum=%h oe=%h pre=%b clr=%b expected sum=%h oe=%h pre=%b clr=%b",
                   e.tag, sumOut, oeTerm, syncPreset, asyncClear, e.sum, e.oe, e.pre, e.clr);
        end
      end
    end
  end

  function automatic logic [MB-1:0] withBit(input logic [MB-1:0] c, input int t, input int l);
    logic [MB-1:0] r;
    r = c;
    r[t*NL+l] = 1'b1;
    return r;
  endfunction

  function automatic logic [MB-1:0] contraTerm(input logic [MB-1:0] c, input int t);
    logic [MB-1:0] r;
    r = c;
    r[t*NL +: 2] = 2'b11;
    return r;
  endfunction

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !doneFlag) begin
      doneFlag = 1'b1;
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [MB-1:0] c;
    repeat (3) @(posedge clk);
    // Reset state: erased configuration, every term open -> all outputs high (R2).
    applyVec('0, '0, '0, "R2 reset erased array");
    rst = 1'b0;
    applyVec('0, 10'h3FF, 8'hA5, "R2 open terms ignore inputs");
    // Every bit set: every term contradictory (R3).
    applyVec('1, 10'h155, 8'h3C, "R3 all terms contradictory");
    // Single true / complement connections on preset and clear (R1, R6).
    for (int s = 0; s < NP; s++) begin
      c = withBit('0, TERM_PRESET, 2*s);
      c = withBit(c, TERM_CLEAR, 2*s+1);
      applyVec(c, 10'(1 << s), '0, "R1 R6 pin high on true/comp lines");
      applyVec(c, ~10'(1 << s), '1, "R1 R6 pin low on true/comp lines");
    end
    // Feedback lines on enable terms (R7, R5).
    c = '0;
    for (int g = 0; g < NO; g++) c = withBit(c, NSOP + g, 2*(NP+g));
    applyVec(c, '0, 8'h5A, "R7 R5 feedback true lines to enables");
    applyVec(c, '1, 8'hC3, "R7 R5 feedback true lines to enables");
    c = '0;
    for (int g = 0; g < NO; g++) c = withBit(c, NSOP + g, 2*(NP+g)+1);
    applyVec(c, '0, 8'h96, "R7 R5 feedback complement lines");
    // Group boundaries: only term g*8+k open, rest contradictory (R4).
    for (int g = 0; g < NO; g++) begin
      c = '0;
      for (int t = 0; t < NSOP; t++) if (t != g*TPO + (g % TPO)) c = contraTerm(c, t);
      applyVec(c, 10'h2A5, 8'h11, "R4 single open term selects group");
      c = '0;
      for (int t = 0; t < NSOP; t++) if (t != g*TPO + TPO-1) c = contraTerm(c, t);
      applyVec(c, '0, '0, "R4 last term of group");
    end
    // Multi-line AND: pin0 true and pin3 complement on term 0 only (R9).
    c = '0;
    for (int t = 1; t < NSOP; t++) c = contraTerm(c, t);
    c = withBit(c, 0, 0);
    c = withBit(c, 0, 7);
    for (int v = 0; v < 4; v++) begin
      applyVec(c, 10'((v & 1) | ((v >> 1) << 3)), '0, "R9 two-line AND");
    end
    // Random sparse configurations against the model (R4, R8, R9).
    for (int i = 0; i < 300; i++) begin
      c = '0;
      for (int b = 0; b < MB; b++) c[b] = ($urandom_range(0, 11) == 0);
      applyVec(c, 10'($urandom), 8'($urandom), "R4 R8 random configuration");
      applyVec(c, 10'($urandom), 8'($urandom), "R8 input change same config");
    end
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule